// File: doc/BRIEF.md
# Dual Gated Timer/Counter Pair

This block holds two independent 16-bit counting units, each built from a low and a high byte. A unit counts either a strobe taken from a free-running clock prescaler (timer operation) or falling edges seen on its own external count pin (counter operation). One of four counting layouts is selected per unit: 13-bit, 16-bit, 8-bit with automatic reload from the high byte, and a split layout. In the split layout, unit 0's high byte becomes a separate 8-bit timer that borrows unit 1's run bit and overflow flag.

Software reaches the block through a simple byte-wide register port with a registered read path. Each unit has a run bit. When a unit's gate bit is set, the unit counts only while its gate pin is high. An overflow sets a sticky flag, which the interrupt logic outside this block consumes and clears through a per-unit clear input. Every overflow of unit 1 is also sent out as a single-cycle tick for a baud-rate generator.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset, all counter bytes, the mode register, the run bits, the flags, `rdata` and `baud_tick` are zero.
- R2: Register addresses are 0 = unit 0 low byte, 1 = unit 0 high byte, 2 = unit 1 low byte, 3 = unit 1 high byte, 4 = mode, 5 = control. `rdata` shows the addressed register one clock after `addr` is applied. The mode byte holds unit 0's fields in bits 3:0 and unit 1's in bits 7:4, with the same layout in each nibble: bits 1:0 select the layout, bit 2 selects counter operation, bit 3 is the gate enable. The control byte has bit 0 = run 0, bit 1 = flag 0, bit 2 = run 1, bit 3 = flag 1, and bits 7:4 read as zero.
- R3: In timer operation, a running unit advances once every PRESCALE (default 12) clocks. A run window of exactly 12*K clocks advances it by K.
- R4: In counter operation, a unit advances once for each 1-to-0 transition of its count pin, provided each pin level is held for longer than one prescale period.
- R5: With its gate bit set, a unit counts only while its gate pin is high. With its run bit clear, the unit never counts.
- R6: Layout 0 (13-bit): low bits 4:0 count, and a carry out of bit 4 increments the high byte. Low bits 7:5 are never changed by counting. Overflow occurs when a count leaves 0xFF/0x1F.
- R7: Layout 1 (16-bit): the high and low bytes form one 16-bit counter that wraps from 0xFFFF to 0 with an overflow.
- R8: Layout 2 (reload): the low byte counts, and on overflow from 0xFF it is loaded from the high byte, which does not change.
- R9: Layout 3 on unit 0: the low byte is an 8-bit counter under unit 0's run, gate and source controls. The high byte counts prescaler strobes whenever run 1 is set and sets flag 1 on overflow. While unit 0 is in layout 3, unit 1 ignores its run bit, counts continuously and never sets flag 1. A unit 1 set to layout 3 holds its value.
- R10: An overflow sets the unit's flag. A write to the control register clears a flag whose written bit is 0 and keeps it when the bit is 1. A `flag_clr` pulse clears the flag. A hardware set in the same cycle takes priority over either clear.
- R11: Every overflow of unit 1's counter produces exactly one single-cycle `baud_tick` pulse. This includes overflows that occur while unit 1 is not allowed to set its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| flag_clr | input | 2 | Overflow flag clear, one per unit |
| ov_flag | output | 2 | Sticky overflow flags |
| baud_tick | output | 1 | One-cycle pulse per unit 1 overflow |

## Verification
The bench targets the carry boundaries of each layout: 0xFF/0x1F in the 13-bit layout, 0xFFFF in the 16-bit layout and 0xFF in the reload layout. A design with the wrong carry bit, or one that reloads from the wrong byte, reads back a wrong count or a missing flag. Split mode is checked in both directions. The high byte must follow run 1 and raise flag 1, while unit 1's own overflow must still produce a baud tick without touching flag 1. A design that mixes up the borrowed controls leaves the high byte frozen or flags the wrong unit. Gating with the pin held low, falling-edge counting on the count pin, and the keep-or-clear control-write rule for flags are also exercised. These catch a design that counts levels instead of edges, or one that loses a flag on every stop write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    LAY_13     = 2'd0,
    LAY_16     = 2'd1,
    LAY_RELOAD = 2'd2,
    LAY_SPLIT  = 2'd3
  } layout_e;

  // per-unit nibble of the mode register, MSB first
  typedef struct packed {
    logic    gate_en;
    logic    ext_src;
    layout_e layout;
  } unit_cfg_t;

  localparam logic [2:0] A_U0_LO = 3'd0;
  localparam logic [2:0] A_U0_HI = 3'd1;
  localparam logic [2:0] A_U1_LO = 3'd2;
  localparam logic [2:0] A_U1_HI = 3'd3;
  localparam logic [2:0] A_MODE  = 3'd4;
  localparam logic [2:0] A_CTRL  = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int UNITS       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [UNITS-1:0] cnt_pin,
  input  logic [UNITS-1:0] gate_pin,
  output logic             tick,
  output logic [UNITS-1:0] cnt_evt,
  output logic [UNITS-1:0] gate_lvl
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PS_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    ps_q;
  logic [UNITS-1:0] pin_s;
  logic [UNITS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)          ps_q <= '0;
    else if (tick)    ps_q <= '0;
    else              ps_q <= ps_q + 1'b1;
  end
  assign tick = (ps_q == PS_LAST);

  for (genvar u = 0; u < UNITS; u++) begin : g_sync
    logic [SYNC_STAGES-1:0] cs_q;
    logic [SYNC_STAGES-1:0] gs_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cs_q <= '0;
        gs_q <= '0;
      end else begin
        cs_q <= {cs_q[SYNC_STAGES-2:0], cnt_pin[u]};
        gs_q <= {gs_q[SYNC_STAGES-2:0], gate_pin[u]};
      end
    end
    assign pin_s[u]    = cs_q[SYNC_STAGES-1];
    assign gate_lvl[u] = gs_q[SYNC_STAGES-1];
  end

  // pin sampled once per strobe; event = high on last strobe, low now
  always_ff @(posedge clk) begin
    if (rst)       prev_q <= '0;
    else if (tick) prev_q <= pin_s;
  end
  assign cnt_evt = {UNITS{tick}} & prev_q & ~pin_s;

  if (PRESCALE > 1) begin : g_ast
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);  // R3
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  layout_e       layout,
  input  logic          inc,
  input  logic          hi_inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic          ovf,
  output logic          hi_ovf
);
  localparam int PRE = 5;  // low bits used by the 13-bit layout
  localparam logic [BW-1:0] ONES = '1;

  logic [BW-1:0] lo_n, hi_n;

  always_comb begin
    lo_n   = lo;
    hi_n   = hi;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    unique case (layout)
      LAY_13: if (inc) begin
        lo_n[PRE-1:0] = lo[PRE-1:0] + 1'b1;
        if (&lo[PRE-1:0]) begin
          hi_n = hi + 1'b1;
          ovf  = (hi == ONES);
        end
      end
      LAY_16: if (inc) begin
        {hi_n, lo_n} = {hi, lo} + {{(2*BW-1){1'b0}}, 1'b1};
        ovf          = &{hi, lo};
      end
      LAY_RELOAD: if (inc) begin
        if (lo == ONES) begin
          lo_n = hi;
          ovf  = 1'b1;
        end else begin
          lo_n = lo + 1'b1;
        end
      end
      default: begin
        if (inc) begin
          lo_n = lo + 1'b1;
          ovf  = (lo == ONES);
        end
        if (hi_inc) begin
          hi_n   = hi + 1'b1;
          hi_ovf = (hi == ONES);
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (rst)
    (layout == LAY_RELOAD && inc && lo == ONES && !wr_lo && !wr_hi)
      |=> (lo == $past(hi) && $stable(hi)));  // R8
  AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (layout == LAY_13 && !wr_lo)
      |=> (lo[BW-1:PRE] == $past(lo[BW-1:PRE])));  // R6
  AST_WRAP_16: assert property (@(posedge clk) disable iff (rst)
    (layout == LAY_16 && inc && hi == ONES && lo == ONES && !wr_lo && !wr_hi)
      |=> (lo == '0 && hi == '0));  // R7
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic [1:0]    flag_clr,
  output logic [1:0]    ov_flag,
  output logic          baud_tick
);
  localparam int NU = 2;

  logic          tick;
  logic [NU-1:0] evt, glvl;
  logic [DW-1:0] mode_q;
  logic [NU-1:0] run_q, flag_q, flag_n;
  logic          baud_q;
  logic [DW-1:0] rd_q;
  unit_cfg_t     cfg [NU];
  logic          split;
  logic [NU-1:0] inc, hinc, ovf, hovf, set, wlo, whi;
  logic [DW-1:0] lo [NU];
  logic [DW-1:0] hi [NU];
  logic          wr_mode, wr_ctrl;

  tmr_tick_gen #(.PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES), .UNITS(NU)) i_tick (
    .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .tick(tick), .cnt_evt(evt), .gate_lvl(glvl)
  );

  assign wr_mode = wr_en && (addr == AW'(A_MODE));
  assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
  assign split   = (cfg[0].layout == LAY_SPLIT);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic src, allow;
    assign cfg[u] = unit_cfg_t'(mode_q[4*u +: 4]);
    assign src    = cfg[u].ext_src ? evt[u] : tick;
    assign wlo[u] = wr_en && (addr == AW'(2*u));
    assign whi[u] = wr_en && (addr == AW'(2*u + 1));
    if (u == 0) begin : g_u0
      assign allow   = run_q[0];
      assign hinc[u] = split && run_q[1] && tick;
      assign set[u]  = ovf[0];
    end else begin : g_u1
      assign allow   = (split || run_q[1]) && (cfg[u].layout != LAY_SPLIT);
      assign hinc[u] = 1'b0;
      assign set[u]  = split ? hovf[0] : (ovf[1] | hovf[1]);
    end
    assign inc[u] = allow && (!cfg[u].gate_en || glvl[u]) && src;

    tmr_unit #(.BW(DW)) i_unit (
      .clk(clk), .rst(rst), .layout(cfg[u].layout), .inc(inc[u]),
      .hi_inc(hinc[u]), .wr_lo(wlo[u]), .wr_hi(whi[u]), .wdata(wdata),
      .lo(lo[u]), .hi(hi[u]), .ovf(ovf[u]), .hi_ovf(hovf[u])
    );
  end

  always_comb begin
    flag_n = flag_q;
    if (wr_ctrl) flag_n = flag_n & {wdata[3], wdata[1]};
    flag_n = (flag_n & ~flag_clr) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ctrl) run_q  <= {wdata[2], wdata[0]};
      flag_q <= flag_n;
      baud_q <= ovf[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (addr)
        AW'(A_U0_LO): rd_q <= lo[0];
        AW'(A_U0_HI): rd_q <= hi[0];
        AW'(A_U1_LO): rd_q <= lo[1];
        AW'(A_U1_HI): rd_q <= hi[1];
        AW'(A_MODE):  rd_q <= mode_q;
        AW'(A_CTRL):  rd_q <= {{(DW-4){1'b0}}, flag_q[1], run_q[1], flag_q[0], run_q[0]};
        default:      rd_q <= '0;
      endcase
    end
  end

  assign rdata     = rd_q;
  assign ov_flag   = flag_q;
  assign baud_tick = baud_q;

  AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    ovf[0] |=> ov_flag[0]);  // R10
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[1] && !set[1]) |=> !ov_flag[1]);  // R10
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].gate_en && !glvl[0] && !wlo[0]) |=> $stable(lo[0]));  // R5
  AST_SPLIT_NO_U1_FLAG: assert property (@(posedge clk) disable iff (rst)
    (split && !hovf[0] && !ov_flag[1]) |=> !ov_flag[1]);  // R9
  AST_BAUD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ovf[1] |=> baud_tick);  // R11
endmodule

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] flag_clr = 2'b00;
  logic [1:0] ov_flag;
  logic       baud_tick;

  int n_chk = 0;
  int n_bad = 0;
  int baud_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_pair i_tmr_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .flag_clr(flag_clr), .ov_flag(ov_flag), .baud_tick(baud_tick)
  );

  always @(negedge clk) if (baud_tick) baud_cnt++;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // run for exactly 12*k clocks with run bits 'runs', flags kept on stop
  task automatic run_win(input logic [7:0] runs, input int k);
    wr(3'd5, 8'h0A | runs);
    repeat (12 * k - 1) @(negedge clk);
    wr(3'd5, 8'h0A);
  endtask

  // reference counting from the requirements (R6, R7, R8)
  task automatic model(input int lay, input logic [7:0] lo_i, input logic [7:0] hi_i,
                       input int k, output logic [7:0] lo_o, output logic [7:0] hi_o,
                       output int nov);
    logic [15:0] w;
    lo_o = lo_i; hi_o = hi_i; nov = 0;
    for (int i = 0; i < k; i++) begin
      case (lay)
        0: begin
          if (lo_o[4:0] == 5'h1f) begin
            if (hi_o == 8'hff) nov++;
            hi_o = hi_o + 8'd1;
          end
          lo_o[4:0] = lo_o[4:0] + 5'd1;
        end
        1: begin
          w = {hi_o, lo_o};
          if (w == 16'hffff) nov++;
          w = w + 16'd1;
          {hi_o, lo_o} = w;
        end
        default: begin
          if (lo_o == 8'hff) begin
            lo_o = hi_o; nov++;
          end else lo_o = lo_o + 8'd1;
        end
      endcase
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    logic [7:0] d, elo, ehi;
    int nov;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d, 0, $sformatf("R1 reg%0d", a));
    end
    chk(ov_flag, 0, "R1 flags");
    chk(baud_tick, 0, "R1 baud");

    // R2: register map readback
    wr(3'd4, 8'hA5); rd(3'd4, d); chk(d, 8'hA5, "R2 mode");
    wr(3'd0, 8'h3C); rd(3'd0, d); chk(d, 8'h3C, "R2 u0 lo");
    wr(3'd3, 8'hC3); rd(3'd3, d); chk(d, 8'hC3, "R2 u1 hi");
    wr(3'd5, 8'hFF); rd(3'd5, d); chk(d, 8'h05, "R2 ctrl");
    wr(3'd5, 8'h00); wr(3'd4, 8'h00);

    // R6: 13-bit carry boundary, top low bits kept
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    run_win(8'h01, 1);
    rd(3'd0, d); chk(d, 8'hE0, "R6 lo");
    rd(3'd1, d); chk(d, 8'h00, "R6 hi");
    rd(3'd5, d); chk(d, 8'h02, "R6 flag");

    // R7: 16-bit wrap
    wr(3'd5, 8'h00); wr(3'd4, 8'h01);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    run_win(8'h01, 3);
    rd(3'd0, d); chk(d, 8'h01, "R7 lo");
    rd(3'd1, d); chk(d, 8'h00, "R7 hi");
    rd(3'd5, d); chk(d, 8'h02, "R7 flag");

    // R8: reload from high byte
    wr(3'd5, 8'h00); wr(3'd4, 8'h02);
    wr(3'd0, 8'hFE); wr(3'd1, 8'h80);
    run_win(8'h01, 3);
    rd(3'd0, d); chk(d, 8'h81, "R8 lo");
    rd(3'd1, d); chk(d, 8'h80, "R8 hi");
    rd(3'd5, d); chk(d, 8'h02, "R8 flag");

    // R4: falling edges on count pin 0
    wr(3'd5, 8'h00); wr(3'd4, 8'h05);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    repeat (40) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      cnt_pin[0] = 1'b0; repeat (30) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (30) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    wr(3'd5, 8'h00);
    rd(3'd0, d); chk(d, 5, "R4 events");

    // R5: gate low blocks unit 1, gate high lets it count
    wr(3'd4, 8'h90);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_win(8'h04, 10);
    rd(3'd2, d); chk(d, 0, "R5 gated");
    gate_pin[1] = 1'b1; repeat (10) @(negedge clk);
    run_win(8'h04, 10);
    rd(3'd2, d); chk(d, 10, "R5 open");
    run_win(8'h00, 10);
    rd(3'd2, d); chk(d, 10, "R5 run off");
    gate_pin[1] = 1'b0;

    // R9/R11: split, unit 1 counts on its own, baud but no flag 1
    wr(3'd5, 8'h00); wr(3'd4, 8'h10);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h00); wr(3'd1, 8'h50);
    baud_cnt = 0;
    wr(3'd4, 8'h13);
    run_win(8'h01, 5);
    rd(3'd0, d); chk(d, 5, "R9 split lo");
    rd(3'd1, d); chk(d, 8'h50, "R9 hi needs run1");
    rd(3'd5, d); chk(d, 8'h00, "R9 no flag1");
    chk(baud_cnt, 1, "R11 baud in split");

    // R9: split high byte on run 1 sets flag 1
    wr(3'd0, 8'hF0); wr(3'd1, 8'hFE);
    run_win(8'h05, 20);
    rd(3'd0, d); chk(d, 8'h04, "R9 lo");
    rd(3'd1, d); chk(d, 8'h12, "R9 hi");
    rd(3'd5, d); chk(d, 8'h0A, "R9 flags");

    // R10: clear input and control write rule
    flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
    rd(3'd5, d); chk(d, 8'h08, "R10 clr input");
    wr(3'd5, 8'h02);
    rd(3'd5, d); chk(d, 8'h00, "R10 write clears");

    // R3/R6/R7/R8/R11: random layouts, values and windows
    for (int it = 0; it < 20; it++) begin
      int u, lay, k;
      logic [7:0] l0, h0;
      u   = $urandom % 2;
      lay = $urandom % 3;
      k   = 1 + $urandom % 300;
      l0  = 8'($urandom);
      h0  = 8'($urandom);
      if (it < 3) begin h0 = 8'hFF; l0 = 8'hF8; end
      wr(3'd5, 8'h00);
      wr(3'd4, (u == 0) ? 8'(lay) : 8'(lay << 4));
      wr(3'(2 * u), l0); wr(3'(2 * u + 1), h0);
      baud_cnt = 0;
      run_win((u == 0) ? 8'h01 : 8'h04, k);
      model(lay, l0, h0, k, elo, ehi, nov);
      rd(3'(2 * u), d);     chk(d, elo, $sformatf("R3 lo u%0d lay%0d k%0d", u, lay, k));
      rd(3'(2 * u + 1), d); chk(d, ehi, $sformatf("R3 hi u%0d lay%0d k%0d", u, lay, k));
      rd(3'd5, d);
      chk(d, (nov > 0) ? ((u == 0) ? 8'h02 : 8'h08) : 8'h00, "R10 random flag");
      if (u == 1) chk(baud_cnt, nov, "R11 baud count");
    end

    done = 1'b1;
    finish_up();
  end
endmodule